// File: doc/BRIEF.md
# Limb-Sliced 32-bit Unsigned Add and Multiply Unit

This unit does unsigned 32-bit addition and multiplication on operands that arrive split into narrow limbs. Each operand has three 12-bit limbs, so one arithmetic column never needs a wide adder. For every column the unit returns the result limb and the carry that column passes to the next one. A consumer that has to show how each result limb was formed gets the whole carry chain, not only the final value.

A request holds two limb vectors and an operation code. Addition finishes in a single execute cycle. Multiplication is done in schoolbook form, one product column per cycle, which gives five columns for three-limb operands. The unchecked operations return the low 32 bits and raise an overflow flag. The checked operations return every raw column limb and report overflow as a fault. An unknown operation code, or a top limb that does not fit a 32-bit value, is answered with an error response that carries zero data. Both sides of the unit use valid/ready handshakes.

Top module: `u32_limb_arith`

## Requirements
- R1: An operand is three 12-bit limbs, least significant first. Limb k sits in bits [12k+11:12k] of `reqA`/`reqB`, and the value is limb0 + limb1·2^12 + limb2·2^24. `rspLimbs` uses the same packing for five limbs, and `rspCarry` packs five 16-bit carries, carry k in bits [16k+15:16k].
- R2: Operation codes are 0 = add, 1 = multiply, 2 = checked add, 3 = checked multiply. Codes 4 to 7 give fault code 3 (bad operation), with all limbs, all carries and the overflow flag at zero. This takes priority over R3.
- R3: A valid operation in which the top limb of either operand is 256 or more gives fault code 2 (input range), with all limbs, all carries and the overflow flag at zero.
- R4: For addition, raw limb k is (a_k + b_k + carry_{k-1}) mod 4096 and carry k is the quotient, for k = 0..2, with carry_{-1} = 0. Raw limbs 3 and 4 and carries 3 and 4 are zero.
- R5: For multiplication, column k (k = 0..4) sums every a_i·b_j with i + j = k and adds carry_{k-1}. The raw limb is that total mod 4096 and the carry is the total divided by 4096.
- R6: An unchecked operation returns the low 32 bits of the true result: limbs 0 and 1 raw, limb 2 holding bits 31..24, limbs 3 and 4 zero, fault code 0 even when overflow occurs. Carries are always reported raw.
- R7: `rspOverflow` is 1 exactly when the true result needs more than 32 bits. That is the case when raw limb 2 is 256 or more, when raw limb 3 or 4 is nonzero, or when carry 2, 3 or 4 is nonzero.
- R8: A checked operation returns all five raw limbs. Its fault code is 1 (overflow) when R7 flags overflow and 0 otherwise.
- R9: `rspValid` rises one cycle after the accepting edge for add and error responses, and five cycles after it for a multiply.
- R10: Out of reset `reqReady` is 1 and `rspValid` is 0. `reqReady` stays low from acceptance until the response has been taken, and a response stays stable while `rspValid` is high and `rspReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqA | input | 36 | First operand, three limbs |
| reqB | input | 36 | Second operand, three limbs |
| reqOp | input | 3 | Operation code |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| rspLimbs | output | 60 | Five result limbs |
| rspCarry | output | 80 | Five column carries |
| rspOverflow | output | 1 | Result does not fit 32 bits |
| rspFault | output | 2 | 0 none, 1 checked overflow, 2 input range, 3 bad operation |

## Verification
The hardest case to reach from the ports is a product whose high column limbs come out zero while a late carry is still nonzero. 2^30·2^30 is such a case: only carry 4 shows the overflow. Directed operands with large powers of two drive this case in both the unchecked and the checked variant. A stalling consumer keeps each response waiting across several cycles, so the hold rule is exercised while the multiply columns keep the control busy. A bad operation code combined with an out-of-range top limb probes the priority between the two error kinds.

// File: rtl/u32_limb_pkg.sv
package u32_limb_pkg;

  // operation codes carried on reqOp
  localparam int OP_ADD  = 0;
  localparam int OP_MUL  = 1;
  localparam int OP_CADD = 2;
  localparam int OP_CMUL = 3;
  localparam int NUM_OPS = 4;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OVF   = 2'd1,
    FLT_RANGE = 2'd2,
    FLT_OP    = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request operands, clear results
    logic finishOne;  // single-cycle completion (add or error)
    logic stepCol;    // compute one product column
  } strobe_t;

endpackage

// File: rtl/u32_limb_datapath.sv
module u32_limb_datapath
  import u32_limb_pkg::*;
#(
  parameter int LIMB_W    = 12,
  parameter int NUM_LIMBS = 3,
  parameter int TOP_W     = 8,
  parameter int OP_W      = 3,
  parameter int NUM_COLS  = 2 * NUM_LIMBS - 1,
  parameter int CARRY_W   = LIMB_W + $clog2(NUM_LIMBS) + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [NUM_LIMBS*LIMB_W-1:0]   reqA,
  input  logic [NUM_LIMBS*LIMB_W-1:0]   reqB,
  input  logic [OP_W-1:0]               reqOp,
  output logic                          isMul,
  output logic                          errFlag,
  output logic                          lastCol,
  output logic [NUM_COLS*LIMB_W-1:0]    rspLimbs,
  output logic [NUM_COLS*CARRY_W-1:0]   rspCarry,
  output logic                          rspOverflow,
  output fault_e                        rspFault
);

  localparam int SUM_W = LIMB_W + CARRY_W;
  localparam int CI_W  = $clog2(NUM_COLS);

  logic [LIMB_W-1:0]  opA [NUM_LIMBS];
  logic [LIMB_W-1:0]  opB [NUM_LIMBS];
  logic [OP_W-1:0]    opSel;
  logic [LIMB_W-1:0]  resLimb  [NUM_COLS];
  logic [CARRY_W-1:0] resCarry [NUM_COLS];
  logic [CI_W-1:0]    colIdx;
  fault_e             errCode;

  logic opValid, isChecked, rangeBad, rawOvf, keepRaw;
  logic [LIMB_W-1:0]  addLimb  [NUM_LIMBS];
  logic [CARRY_W-1:0] addCarry [NUM_LIMBS];
  logic [SUM_W-1:0]   colSum;

  // operation decode and input range check
  assign opValid   = opSel < OP_W'(NUM_OPS);
  assign isMul     = (opSel == OP_W'(OP_MUL)) || (opSel == OP_W'(OP_CMUL));
  assign isChecked = (opSel == OP_W'(OP_CADD)) || (opSel == OP_W'(OP_CMUL));
  assign rangeBad  = (|opA[NUM_LIMBS-1][LIMB_W-1:TOP_W]) ||
                     (|opB[NUM_LIMBS-1][LIMB_W-1:TOP_W]);
  assign errFlag   = !opValid || rangeBad;
  assign lastCol   = colIdx == CI_W'(NUM_COLS - 1);

  // ripple carry chain across the operand limbs
  always_comb begin
    logic [SUM_W-1:0]   acc;
    logic [CARRY_W-1:0] cin;
    cin = '0;
    for (int k = 0; k < NUM_LIMBS; k++) begin
      acc = SUM_W'(opA[k]) + SUM_W'(opB[k]) + SUM_W'(cin);
      addLimb[k]  = acc[LIMB_W-1:0];
      addCarry[k] = acc[SUM_W-1:LIMB_W];
      cin = addCarry[k];
    end
  end

  // one schoolbook column: partial products on the anti-diagonal plus carry-in
  always_comb begin
    colSum = '0;
    for (int k = 0; k < NUM_COLS - 1; k++)
      if (CI_W'(k + 1) == colIdx) colSum = SUM_W'(resCarry[k]);
    for (int i = 0; i < NUM_LIMBS; i++)
      for (int j = 0; j < NUM_LIMBS; j++)
        if (CI_W'(i + j) == colIdx)
          colSum = colSum + SUM_W'(opA[i]) * SUM_W'(opB[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LIMBS; k++) begin
        opA[k] <= '0;
        opB[k] <= '0;
      end
      for (int k = 0; k < NUM_COLS; k++) begin
        resLimb[k]  <= '0;
        resCarry[k] <= '0;
      end
      opSel   <= '0;
      colIdx  <= '0;
      errCode <= FLT_NONE;
    end else if (stb.load) begin
      for (int k = 0; k < NUM_LIMBS; k++) begin
        opA[k] <= reqA[k*LIMB_W +: LIMB_W];
        opB[k] <= reqB[k*LIMB_W +: LIMB_W];
      end
      for (int k = 0; k < NUM_COLS; k++) begin
        resLimb[k]  <= '0;
        resCarry[k] <= '0;
      end
      opSel   <= reqOp;
      colIdx  <= '0;
      errCode <= FLT_NONE;
    end else if (stb.finishOne) begin
      if (!opValid) errCode <= FLT_OP;
      else if (rangeBad) errCode <= FLT_RANGE;
      else begin
        for (int k = 0; k < NUM_LIMBS; k++) begin
          resLimb[k]  <= addLimb[k];
          resCarry[k] <= addCarry[k];
        end
      end
    end else if (stb.stepCol) begin
      resLimb[colIdx]  <= colSum[LIMB_W-1:0];
      resCarry[colIdx] <= colSum[SUM_W-1:LIMB_W];
      colIdx           <= colIdx + 1'b1;
    end
  end

  // anything beyond 32 bits: high bits of the top operand limb, higher limbs, late carries
  always_comb begin
    rawOvf = |resLimb[NUM_LIMBS-1][LIMB_W-1:TOP_W];
    for (int k = NUM_LIMBS; k < NUM_COLS; k++) rawOvf = rawOvf || (|resLimb[k]);
    for (int k = NUM_LIMBS - 1; k < NUM_COLS; k++) rawOvf = rawOvf || (|resCarry[k]);
  end

  assign keepRaw     = isChecked || (errCode != FLT_NONE);
  assign rspOverflow = rawOvf;

  always_comb begin
    for (int k = 0; k < NUM_COLS; k++) begin
      rspCarry[k*CARRY_W +: CARRY_W] = resCarry[k];
      if (keepRaw || k < NUM_LIMBS - 1)
        rspLimbs[k*LIMB_W +: LIMB_W] = resLimb[k];
      else if (k == NUM_LIMBS - 1)
        rspLimbs[k*LIMB_W +: LIMB_W] = LIMB_W'(resLimb[k][TOP_W-1:0]);
      else
        rspLimbs[k*LIMB_W +: LIMB_W] = '0;
    end
  end

  assign rspFault = (errCode != FLT_NONE) ? errCode :
                    (isChecked && rawOvf) ? FLT_OVF : FLT_NONE;

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_RANGE || rspFault == FLT_OP) |->
      (rspLimbs == '0 && rspCarry == '0 && !rspOverflow)); // R3

  AST_CHECKED_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_OVF) |-> rspOverflow); // R8

  AST_ADD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finishOne && !errFlag) |=>
      (rspLimbs[NUM_COLS*LIMB_W-1:NUM_LIMBS*LIMB_W] == '0 &&
       rspCarry[NUM_COLS*CARRY_W-1:NUM_LIMBS*CARRY_W] == '0)); // R4

endmodule

// File: rtl/u32_limb_ctrl.sv
module u32_limb_ctrl
  import u32_limb_pkg::*;
#(
  parameter int NUM_COLS = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    rspValid,
  input  logic    rspReady,
  input  logic    isMul,
  input  logic    errFlag,
  input  logic    lastCol,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(NUM_COLS + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} state_e;
  state_e state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    reqReady = (state == ST_IDLE);
    rspValid = (state == ST_RESP);
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.load = 1'b1;
        stateNxt = ST_EXEC;
      end
      ST_EXEC: if (errFlag || !isMul) begin
        stb.finishOne = 1'b1;
        stateNxt      = ST_RESP;
      end else begin
        stb.stepCol = 1'b1;
        if (lastCol) stateNxt = ST_RESP;
      end
      ST_RESP: if (rspReady) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // cycles spent executing the current request
  logic [CNT_W-1:0] execCycles;
  always_ff @(posedge clk) begin
    if (!rstN || stb.load) execCycles <= '0;
    else if (state == ST_EXEC) execCycles <= execCycles + 1'b1;
  end

  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R10

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> (execCycles == CNT_W'(1) || execCycles == CNT_W'(NUM_COLS))); // R9

endmodule

// File: rtl/u32_limb_arith.sv
module u32_limb_arith
  import u32_limb_pkg::*;
#(
  parameter int LIMB_W    = 12,
  parameter int NUM_LIMBS = 3,
  parameter int TOP_W     = 8,
  parameter int OP_W      = 3,
  parameter int NUM_COLS  = 2 * NUM_LIMBS - 1,
  parameter int CARRY_W   = LIMB_W + $clog2(NUM_LIMBS) + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [NUM_LIMBS*LIMB_W-1:0] reqA,
  input  logic [NUM_LIMBS*LIMB_W-1:0] reqB,
  input  logic [OP_W-1:0]             reqOp,
  output logic                        rspValid,
  input  logic                        rspReady,
  output logic [NUM_COLS*LIMB_W-1:0]  rspLimbs,
  output logic [NUM_COLS*CARRY_W-1:0] rspCarry,
  output logic                        rspOverflow,
  output logic [1:0]                  rspFault
);

  strobe_t stb;
  logic    isMul, errFlag, lastCol;
  fault_e  faultCode;

  u32_limb_ctrl #(.NUM_COLS(NUM_COLS)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .isMul(isMul), .errFlag(errFlag), .lastCol(lastCol),
    .stb(stb)
  );

  u32_limb_datapath #(
    .LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS), .TOP_W(TOP_W), .OP_W(OP_W),
    .NUM_COLS(NUM_COLS), .CARRY_W(CARRY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqA(reqA), .reqB(reqB), .reqOp(reqOp),
    .isMul(isMul), .errFlag(errFlag), .lastCol(lastCol),
    .rspLimbs(rspLimbs), .rspCarry(rspCarry),
    .rspOverflow(rspOverflow), .rspFault(faultCode)
  );

  assign rspFault = faultCode;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=>
      (rspValid && $stable(rspLimbs) && $stable(rspCarry) &&
       $stable(rspOverflow) && $stable(rspFault))); // R10

endmodule

// File: tb/test_u32_limb_arith.sv
module test_u32_limb_arith;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int NC = 5;
  localparam int LW = 12;
  localparam int CW = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [NL*LW-1:0]   reqA = '0;
  logic [NL*LW-1:0]   reqB = '0;
  logic [2:0]         reqOp = '0;
  logic               rspValid;
  logic               rspReady = 1'b0;
  logic [NC*LW-1:0]   rspLimbs;
  logic [NC*CW-1:0]   rspCarry;
  logic               rspOverflow;
  logic [1:0]         rspFault;

  u32_limb_arith i_u32_limb_arith (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqA(reqA), .reqB(reqB), .reqOp(reqOp),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspLimbs(rspLimbs), .rspCarry(rspCarry),
    .rspOverflow(rspOverflow), .rspFault(rspFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  stallMode = 1'b0;
  bit  inFlight  = 1'b0;

  // scoreboard queues
  logic [NC*LW-1:0] qLimbs[$];
  logic [NC*CW-1:0] qCarry[$];
  logic             qOvf[$];
  logic [1:0]       qFault[$];
  int               qLat[$];
  int               qAcc[$];
  string            qTag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // reference model straight from the requirements
  task automatic model(input logic [NL*LW-1:0] a, input logic [NL*LW-1:0] b,
                       input logic [2:0] op, output logic [NC*LW-1:0] lim,
                       output logic [NC*CW-1:0] car, output logic ovf,
                       output logic [1:0] flt, output int lat);
    longint unsigned al[NL], bl[NL], av, bv, truth, s, cin;
    logic [LW-1:0] rawL[NC];
    logic [CW-1:0] rawH[NC];
    bit mul, checked;
    lim = '0; car = '0; ovf = 1'b0; flt = 2'd0; lat = 1;
    for (int k = 0; k < NL; k++) begin
      al[k] = longint'(a[k*LW +: LW]);
      bl[k] = longint'(b[k*LW +: LW]);
    end
    if (op > 3'd3) begin
      flt = 2'd3;                                  // R2
    end else if (al[NL-1] >= 256 || bl[NL-1] >= 256) begin
      flt = 2'd2;                                  // R3
    end else begin
      mul = (op == 3'd1) || (op == 3'd3);
      checked = op >= 3'd2;
      av = al[0] + (al[1] << 12) + (al[2] << 24);
      bv = bl[0] + (bl[1] << 12) + (bl[2] << 24);
      truth = mul ? av * bv : av + bv;
      ovf = truth >= 64'h1_0000_0000;              // R7
      cin = 0;
      for (int k = 0; k < NC; k++) begin
        rawL[k] = '0; rawH[k] = '0;
      end
      for (int k = 0; k < (mul ? NC : NL); k++) begin
        s = cin;
        if (mul) begin
          for (int i = 0; i < NL; i++)
            for (int j = 0; j < NL; j++)
              if (i + j == k) s += al[i] * bl[j];
        end else begin
          s += al[k] + bl[k];
        end
        rawL[k] = LW'(s % 4096);
        rawH[k] = CW'(s / 4096);
        cin = s / 4096;
      end
      for (int k = 0; k < NC; k++) car[k*CW +: CW] = rawH[k];
      if (checked) begin
        for (int k = 0; k < NC; k++) lim[k*LW +: LW] = rawL[k];
        flt = ovf ? 2'd1 : 2'd0;                   // R8
      end else begin
        lim[11:0]  = truth[11:0];                  // R6
        lim[23:12] = truth[23:12];
        lim[35:24] = LW'(truth[31:24]);
      end
      lat = mul ? 5 : 1;                           // R9
    end
  endtask

  task automatic send(input logic [NL*LW-1:0] a, input logic [NL*LW-1:0] b,
                      input logic [2:0] op, input string tagOv);
    logic [NC*LW-1:0] lim;
    logic [NC*CW-1:0] car;
    logic ovf;
    logic [1:0] flt;
    int lat;
    string tag;
    model(a, b, op, lim, car, ovf, flt, lat);
    if (tagOv != "") tag = tagOv;
    else if (flt == 2'd3) tag = "R2";
    else if (flt == 2'd2) tag = "R3";
    else if (op >= 3'd2) tag = "R8";
    else if (ovf) tag = "R6";
    else if (op == 3'd1) tag = "R5";
    else tag = "R4";
    @(negedge clk);
    reqValid = 1'b1; reqA = a; reqB = b; reqOp = op;
    while (!reqReady) @(negedge clk);
    qLimbs.push_back(lim); qCarry.push_back(car); qOvf.push_back(ovf);
    qFault.push_back(flt); qLat.push_back(lat); qAcc.push_back(cyc + 1);
    qTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic compareAll(input string tag);
    chk(rspLimbs == qLimbs[0], tag, "limbs", 128'(rspLimbs), 128'(qLimbs[0]));
    chk(rspCarry == qCarry[0], tag, "carries", 128'(rspCarry), 128'(qCarry[0]));
    chk(rspOverflow == qOvf[0], "R7", "overflow", 128'(rspOverflow), 128'(qOvf[0]));
    chk(rspFault == qFault[0], tag, "fault", 128'(rspFault), 128'(qFault[0]));
  endtask

  // monitor: compare on first appearance and again when taken (hold, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (!inFlight) begin
          if (qAcc.size() == 0) begin
            chk(1'b0, "R10", "unexpected response", 128'(1), 128'(0));
          end else begin
            chk(cyc - qAcc[0] == qLat[0], "R9", "latency",
                128'(cyc - qAcc[0]), 128'(qLat[0]));
            compareAll(qTag[0]);
            inFlight = 1'b1;
          end
        end
        if (rspReady && inFlight) begin
          compareAll("R10");
          qLimbs.pop_front(); qCarry.pop_front(); qOvf.pop_front();
          qFault.pop_front(); qLat.pop_front(); qAcc.pop_front(); qTag.pop_front();
          inFlight = 1'b0;
        end
      end
    end
  end

  // consumer readiness, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rspReady = stallMode ? (cyc % 3 == 0) : 1'b1;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 50000) begin
        chk(1'b0, "R9", "watchdog expired", 128'(cyc), 128'(50000));
        summary();
      end
    end
  end

  function automatic logic [NL*LW-1:0] pack(input int unsigned v);
    return {4'h0, v[31:24], v[23:12], v[11:0]};
  endfunction

  initial begin
    int unsigned rnd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10", "reset reqReady", 128'(reqReady), 128'(1));
    chk(rspValid == 1'b0, "R10", "reset rspValid", 128'(rspValid), 128'(0));

    // limb packing: distinct limb values
    send({12'h012, 12'h345, 12'h678}, {12'h001, 12'h002, 12'h003}, 3'd0, "R1");
    send(pack(32'd1), pack(32'd2), 3'd0, "");
    send({12'h000, 12'h000, 12'hFFF}, {12'h000, 12'h000, 12'h001}, 3'd0, "");
    send(pack(32'hFFFF_FFFF), pack(32'd1), 3'd0, "");          // unchecked wrap
    send(pack(32'hFFFF_FFFF), pack(32'd1), 3'd2, "");          // checked overflow
    send(pack(32'h7FFF_FFFF), pack(32'h7FFF_FFFF), 3'd2, "");  // checked, fits
    send(pack(32'd3), pack(32'd5), 3'd1, "");
    send(pack(32'hFFFF), pack(32'hFFFF), 3'd1, "");
    send(pack(32'hFFFF_FFFF), pack(32'hFFFF_FFFF), 3'd1, "");
    send(pack(32'h4000_0000), pack(32'h4000_0000), 3'd1, "");  // only last carry set
    send(pack(32'h4000_0000), pack(32'h4000_0000), 3'd3, "");
    send(pack(32'h0001_0000), pack(32'h0000_FFFF), 3'd3, "");  // checked, fits
    send({12'h100, 12'h000, 12'h001}, pack(32'd1), 3'd0, "");  // range error
    send(pack(32'd1), {12'hFFF, 12'h000, 12'h000}, 3'd3, "");  // range error
    send({12'h200, 12'h000, 12'h000}, pack(32'd1), 3'd5, "");  // bad op wins
    send(pack(32'd7), pack(32'd9), 3'd7, "");

    stallMode = 1'b1;
    rnd = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      int unsigned x, y;
      rnd = rnd * 1664525 + 1013904223; x = rnd;
      rnd = rnd * 1664525 + 1013904223; y = rnd;
      send(pack(x), pack(y), 3'(rnd[9:8]), "");
    end
    stallMode = 1'b0;

    while (qAcc.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
  end

endmodule